// File: doc/BRIEF.md
# Match-Interrupt Watchdog Timer with Lock

This block is a watchdog that runs on a slow clock. A 16-bit up-counter runs freely while the block is enabled. On every cycle the counter's low bits are compared with a programmed match value. A match does not clear the counter. It sets a pending interrupt flag and increments an unhandled-match count. Software feeds the watchdog by acknowledging the interrupt. If it stops doing so, the third consecutive unacknowledged match fires a one-cycle device-reset pulse.

A small write port programs the block. The port has a 2-bit address and 32-bit data. Each accepted write reaches the registers a fixed three cycles later, which stands in for the bus-to-slow-clock crossing. The register map is:

| Address | Content |
|---------|---------|
| 0 | Control word: bit 0 is enable, bits 31:30 are the lock field |
| 1 | Config word: bits 15:0 are the match value, bits 19:16 are the ignore count |
| 2 | Acknowledge: writing bit 0 as 1 clears the pending flag |
| 3 | Mask: bit 0 set to 1 lets the interrupt reach the output |

The ignore count removes that many top bits from the comparison, which shortens the match period to P = 2^(16 − ignore) cycles. The lock field blocks accidental changes to the configuration and needs two writes to open.

Top module: `match_wdog`

## Requirements
- R1: After reset, the outputs are at rest: count 0, pending 0, interrupt 0 and reset pulse 0. The lock is closed (value 3), the match value is 4096, the ignore count is 0, the mask is 0 and the block is disabled.
- R2: A write sampled at clock edge E changes the registers at edge E+3. After an enable write, count_o still reads 0 after edge E+3 and reads 1 after edge E+4.
- R3: While enabled, the counter adds one per cycle, wraps modulo 2^16 and is not cleared by a match. While disabled, it holds 0 and produces no pending flag and no reset pulse. Disabling leaves the pending flag as it is.
- R4: A match occurs on a cycle where the low (16 − ignore) bits of the count equal those bits of the match value. The pending flag rises on the next edge, and count_o then holds match+1 in those bits.
- R5: If the interrupt is never acknowledged, the first match is followed by a second P cycles later and a third 2P cycles later. The third match drives wdt_rst_o high for exactly one cycle. In that same cycle count_o reads 0 and the pending flag reads 0.
- R6: Writing 1 to bit 0 at address 2 clears the pending flag and the unhandled-match count. Acknowledging once per period keeps the reset pulse from ever firing.
- R7: irq_o equals the pending flag ANDed with mask bit 0. The mask has no effect on when the reset pulse fires.
- R8: Writes to the lock field (bits 31:30 at address 0) change the lock state as follows:
  - Writing 3 closes the lock from any state.
  - From state 3, writing 2 moves the lock to state 2.
  - From state 2, writing 0 opens the lock (state 0).
  - Any other write leaves the lock state unchanged.
  - While the lock is not 0, writes to enable, match value and ignore count are ignored. The lock state in force before a control write decides whether that write's enable bit is accepted.
- R9: An accepted control write with enable set to 1 also clears the pending flag and the unhandled-match count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Slow watchdog clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 32 | Write data |
| irq_o | output | 1 | Interrupt request after the mask |
| pend_o | output | 1 | Raw pending flag |
| count_o | output | 16 | Live counter value |
| wdt_rst_o | output | 1 | One-cycle device-reset request |

## Verification
The assertions assume that writes arrive only through the delayed write port. They also assume that an acknowledge write and a match rarely fall in the same cycle; when they do, the match wins and the flag stays set, so the acknowledge property is conditioned on there being no match. The stimulus keeps every setup sequence ahead of the next match by disabling the block before it reconfigures it. It also uses ignore counts of 11 to 15, so that all match values and the full three-match reset window fit within a short run. A single default-match run with no ignored bits covers the reset configuration.

// File: rtl/match_wdog_pkg.sv
`timescale 1ns/1ps
package match_wdog_pkg;
  localparam int DATA_W  = 32;
  localparam int LOCK_LO = 30;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CFG  = 2'd1,
    A_ACK  = 2'd2,
    A_MASK = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    LK_OPEN = 2'b00,
    LK_HALF = 2'b10,
    LK_FULL = 2'b11
  } lock_e;

  typedef struct packed {
    logic              vld;
    reg_addr_e         addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/match_wdog_wrpipe.sv
`timescale 1ns/1ps
module match_wdog_wrpipe
  import match_wdog_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  wr_req_t req_i,
  output wr_req_t req_o
);
  generate
    if (LAT == 0) begin : g_bypass
      assign req_o = req_i;
    end else begin : g_pipe
      wr_req_t stg_q [LAT];
      for (genvar i = 0; i < LAT; i++) begin : g_stg
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= '0;
          else if (i == 0) stg_q[i] <= req_i;
          else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
        end
      end
      assign req_o = stg_q[LAT-1];
    end
  endgenerate
endmodule

// File: rtl/match_wdog_cfg.sv
`timescale 1ns/1ps
module match_wdog_cfg
  import match_wdog_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int IGN_W     = 4,
  parameter int MATCH_RST = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wr_req_t          req_i,
  output logic             en_o,
  output logic [CNT_W-1:0] match_o,
  output logic [IGN_W-1:0] ign_o,
  output logic             mask_o,
  output logic             ack_o
);
  localparam int IGN_LSB = CNT_W;

  lock_e            lock_q;
  logic             en_q, mask_q;
  logic [CNT_W-1:0] match_q;
  logic [IGN_W-1:0] ign_q;
  logic [1:0]       wr_lock;
  logic             open, wr_ctrl, wr_cfg, wr_ack, wr_mask;
  logic             unused_data;

  assign unused_data = ^req_i.data;
  assign wr_lock = req_i.data[LOCK_LO +: 2];
  assign open    = (lock_q == LK_OPEN);
  assign wr_ctrl = req_i.vld && (req_i.addr == A_CTRL);
  assign wr_cfg  = req_i.vld && (req_i.addr == A_CFG);
  assign wr_ack  = req_i.vld && (req_i.addr == A_ACK);
  assign wr_mask = req_i.vld && (req_i.addr == A_MASK);

  // enabling also acknowledges
  assign ack_o = (wr_ack && req_i.data[0]) || (wr_ctrl && open && req_i.data[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= LK_FULL;
      en_q    <= 1'b0;
      mask_q  <= 1'b0;
      match_q <= CNT_W'(MATCH_RST);
      ign_q   <= '0;
    end else begin
      if (wr_ctrl) begin
        if (open) en_q <= req_i.data[0];
        if (wr_lock == 2'b11) lock_q <= LK_FULL;
        else if (lock_q == LK_FULL && wr_lock == 2'b10) lock_q <= LK_HALF;
        else if (lock_q == LK_HALF && wr_lock == 2'b00) lock_q <= LK_OPEN;
      end
      if (wr_cfg && open) begin
        match_q <= req_i.data[CNT_W-1:0];
        ign_q   <= req_i.data[IGN_LSB +: IGN_W];
      end
      if (wr_mask) mask_q <= req_i.data[0];
    end
  end

  assign en_o    = en_q;
  assign match_o = match_q;
  assign ign_o   = ign_q;
  assign mask_o  = mask_q;

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && lock_q != LK_OPEN) |=> ($stable(match_q) && $stable(ign_q))); // R8
  AST_LOCK_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctrl && lock_q != LK_OPEN) |=> $stable(en_q)); // R8
endmodule

// File: rtl/match_wdog_core.sv
`timescale 1ns/1ps
module match_wdog_core #(
  parameter int CNT_W   = 16,
  parameter int IGN_W   = 4,
  parameter int UNH_MAX = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic [IGN_W-1:0] ign_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] count_o,
  output logic             pend_o,
  output logic             rst_o
);
  localparam int UW = $clog2(UNH_MAX + 1);

  logic [CNT_W-1:0] count_q, cmp_mask;
  logic [UW-1:0]    unh_q;
  logic             pend_q, rst_q, hit;

  assign cmp_mask = {CNT_W{1'b1}} >> ign_i;
  assign hit      = en_i && (((count_q ^ match_i) & cmp_mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      pend_q  <= 1'b0;
      unh_q   <= '0;
      rst_q   <= 1'b0;
    end else begin
      rst_q   <= 1'b0;
      count_q <= en_i ? count_q + 1'b1 : '0;
      if (ack_i) begin
        pend_q <= 1'b0;
        unh_q  <= '0;
      end
      if (hit) begin
        if (!ack_i && unh_q == UW'(UNH_MAX)) begin
          rst_q   <= 1'b1;
          count_q <= '0;
          pend_q  <= 1'b0;
          unh_q   <= '0;
        end else begin
          pend_q <= 1'b1;
          unh_q  <= ack_i ? UW'(1) : unh_q + 1'b1;
        end
      end
    end
  end

  assign count_o = count_q;
  assign pend_o  = pend_q;
  assign rst_o   = rst_q;

  AST_DIS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (count_q == '0)); // R3
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q); // R5
  AST_RST_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> (count_q == '0 && !pend_q)); // R5
  AST_RST_AFTER_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(pend_q)); // R5
  AST_UNH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unh_q <= UW'(UNH_MAX)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !hit) |=> !pend_q); // R6
endmodule

// File: rtl/match_wdog.sv
`timescale 1ns/1ps
module match_wdog
  import match_wdog_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int IGN_W     = 4,
  parameter int WR_LAT    = 3,
  parameter int UNH_MAX   = 2,
  parameter int MATCH_RST = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [31:0]      wr_data_i,
  output logic             irq_o,
  output logic             pend_o,
  output logic [CNT_W-1:0] count_o,
  output logic             wdt_rst_o
);
  wr_req_t          req_in, req_dly;
  logic             en, mask, ack;
  logic [CNT_W-1:0] match;
  logic [IGN_W-1:0] ign;

  assign req_in.vld  = wr_en_i;
  assign req_in.addr = reg_addr_e'(wr_addr_i);
  assign req_in.data = wr_data_i;

  match_wdog_wrpipe #(.LAT(WR_LAT)) u_pipe (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_in), .req_o(req_dly)
  );

  match_wdog_cfg #(.CNT_W(CNT_W), .IGN_W(IGN_W), .MATCH_RST(MATCH_RST)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_dly),
    .en_o(en), .match_o(match), .ign_o(ign), .mask_o(mask), .ack_o(ack)
  );

  match_wdog_core #(.CNT_W(CNT_W), .IGN_W(IGN_W), .UNH_MAX(UNH_MAX)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .match_i(match), .ign_i(ign),
    .ack_i(ack), .count_o(count_o), .pend_o(pend_o), .rst_o(wdt_rst_o)
  );

  assign irq_o = pend_o & mask;

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> pend_o); // R7
endmodule

// File: tb/match_wdog_tb_top.sv
`timescale 1ns/1ps
module match_wdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        irq, pend, wdt_rst;
  logic [15:0] count;

  int nvec = 0;
  int nerr = 0;
  int rst_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  match_wdog dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .irq_o(irq), .pend_o(pend), .count_o(count),
    .wdt_rst_o(wdt_rst)
  );

  always @(negedge clk) if (wdt_rst) rst_cnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_pend(int limit);
    for (int n = 0; n < limit && !pend; n++) @(negedge clk);
  endtask

  task automatic run_case(int ign, int m, bit msk);
    int p, n;
    p = 1 << (16 - ign);
    wr(2'd0, 32'h0);
    wr(2'd3, {31'd0, msk});
    wr(2'd1, (ign << 16) | m);
    wr(2'd0, 32'h1);
    settle();
    wait_pend(4 * p + 20);
    chk("R4 match count", count & (p - 1), (m + 1) % p);
    chk("R7 mask gating", irq, msk);
    n = 0;
    do begin @(negedge clk); n++; end while (!wdt_rst && n < 3 * p + 5);
    chk("R5 reset delay", n, 2 * p);
    chk("R5 count cleared", count, 0);
    chk("R5 pend cleared", pend, 0);
    @(negedge clk);
    chk("R5 single pulse", wdt_rst, 0);
  endtask

  initial begin
    int c0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 pend", pend, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst", wdt_rst, 0);

    // locked: enable and config writes dropped
    wr(2'd0, 32'hC000_0001);
    wr(2'd1, 32'h0000_0005);
    settle(); repeat (2) @(negedge clk);
    chk("R8 locked enable", count, 0);
    wr(2'd0, 32'h8000_0000);
    wr(2'd0, 32'h8000_0001);
    settle(); repeat (2) @(negedge clk);
    chk("R8 half unlock", count, 0);
    wr(2'd0, 32'h0000_0000);

    // write latency
    wr(2'd0, 32'h1);
    repeat (3) @(negedge clk);
    chk("R2 latency E+3", count, 0);
    @(negedge clk);
    chk("R2 latency E+4", count, 1);
    repeat (10) @(negedge clk);
    chk("R3 increments", count, 11);
    wr(2'd3, 32'h1);
    wait_pend(5000);
    chk("R4 default match", count, 4097);
    chk("R7 irq unmasked", irq, 1);

    // disable
    wr(2'd0, 32'h0);
    settle(); @(negedge clk);
    chk("R3 disabled zero", count, 0);
    chk("R3 pend kept", pend, 1);
    r0 = rst_cnt;
    repeat (40) @(negedge clk);
    chk("R3 disabled hold", count, 0);
    chk("R3 no reset", rst_cnt, r0);

    for (int ign = 11; ign <= 15; ign++)
      for (int m = 0; m < (1 << (16 - ign)); m++)
        run_case(ign, m, m[0]);

    // acknowledge clears
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h1);
    wr(2'd1, (11 << 16) | 5);
    wr(2'd0, 32'h1);
    settle();
    wait_pend(100);
    wr(2'd2, 32'h1);
    settle();
    chk("R6 ack pend", pend, 0);
    chk("R6 ack irq", irq, 0);
    wait_pend(100);
    chk("R9 pend before", pend, 1);
    wr(2'd0, 32'h1);
    settle();
    chk("R9 enable clears", pend, 0);

    // feeding
    wr(2'd0, 32'h0);
    wr(2'd1, (13 << 16) | 3);
    wr(2'd0, 32'h1);
    r0 = rst_cnt;
    for (int k = 0; k < 12; k++) begin
      wr(2'd2, 32'h1);
      repeat (7) @(negedge clk);
    end
    chk("R6 feeding", rst_cnt, r0);

    // relock blocks disable
    wr(2'd0, 32'hC000_0001);
    wr(2'd0, 32'h0);
    settle();
    c0 = count;
    @(negedge clk);
    chk("R8 relock", count, (c0 + 1) & 16'hFFFF);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule